// File: doc/BRIEF.md
# Banked Dual-Port Distributed RAM

This block is a 128-word by 8-bit memory with one write port and one read port. It is built from eight small tiles, each 32 words by 4 bits. Each bank places two tiles side by side, one for each nibble of the word. Four such banks give the full depth. On both ports the top two address bits choose the bank and the low five bits choose the word inside that bank.

Writes are registered. The rising edge of the clock captures the write enable, address and data. The array itself changes only on the falling edge that follows, half a cycle later. The read side has no clock. The output word follows the read address through the bank multiplexer. When the read enable is low, the block drops its output-enable flag and drives zeros, so a wrapper can share the read and write data wires.

The array starts with a fixed computed pattern. Connecting both addresses to one source gives a single-port RAM. With the `ROM_MODE` parameter set, every write is blocked and the block behaves as a ROM holding that pattern.

Top module: `banked_dpram`

## Requirements
- R1: After start-up, word `a` holds `(a*29 + 90) mod 256`. Asserting reset never changes any array word.
- R2: `wr_en`, `wr_addr` and `wr_data` are sampled on a rising clock edge. The addressed word takes the new value at the next falling edge.
- R3: Between the capturing rising edge and the following falling edge, a read of the written address returns the old word. From that falling edge on, the read returns the new word.
- R4: `wr_addr[6:5]` selects exactly one of four banks for each write. No other word changes, including the words at the bank edges 31/32, 63/64 and 95/96.
- R5: `rd_data` changes combinationally with `rd_addr`, with no clock edge needed. `rd_addr[6:5]` picks the bank and `rd_addr[4:0]` picks the word.
- R6: Both nibbles, bits [7:4] and [3:0], are written and read together as one 8-bit word.
- R7: With `rd_en` low, `rd_oe` is 0 and `rd_data` is all zeros. With `rd_en` high, `rd_oe` is 1.
- R8: With the read address tied to the write address, the written value can be read in the cycle after the write. Back-to-back writes to one address leave the last value.
- R9: With `ROM_MODE` = 1, writes have no effect and every word keeps its start-up value.
- R10: `rst` is synchronous and active high. It clears the captured write request, so a write presented while `rst` is high does not change the array.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock. The rising edge captures writes; the falling edge commits them |
| rst | input | 1 | Synchronous active-high reset of the write capture registers |
| wr_en | input | 1 | Write request |
| wr_addr | input | 7 | Write address: bank in [6:5], word in [4:0] |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Read enable; when low, the output is released |
| rd_addr | input | 7 | Read address: bank in [6:5], word in [4:0] |
| rd_data | output | 8 | Read word, zero when released |
| rd_oe | output | 1 | High while the read bus is driven |

## Verification
A table of writes is walked first. It hits the first and last word of every bank, and its values differ in both nibbles, so a wrong bank decode or a swapped nibble shows up in the full 128-word readback that follows.

Each write is probed three times: before capture, between capture and commit, and after commit. These probes separate a commit on the falling edge from one on the rising edge, and from a read path that goes through a register.

Directed cases cover the following:
- a write held during reset;
- reset leaving the contents alone;
- the read-enable release;
- back-to-back writes to one address;
- a read address changed twice inside one clock phase;
- a second instance in ROM mode that sees the same write traffic.

// File: rtl/bdpram_pkg.sv
`timescale 1ns/1ps
package bdpram_pkg;
    localparam int TILE_WORDS = 32;
    localparam int TILE_BITS  = 4;
    localparam int NUM_BANKS  = 4;
    localparam int LANES      = 2;

    localparam int WORD_BITS  = TILE_BITS * LANES;
    localparam int OFS_BITS   = $clog2(TILE_WORDS);
    localparam int BANK_BITS  = $clog2(NUM_BANKS);
    localparam int ADDR_BITS  = OFS_BITS + BANK_BITS;
    localparam int PAT_MUL    = 29;
    localparam int PAT_ADD    = 90;

    typedef logic [ADDR_BITS-1:0] addr_t;
    typedef logic [WORD_BITS-1:0] word_t;
    typedef logic [OFS_BITS-1:0]  ofs_t;
    typedef logic [BANK_BITS-1:0] bank_t;

    typedef struct packed {
        logic  en;
        addr_t addr;
        word_t data;
    } wr_cmd_t;

    function automatic bank_t bank_of(addr_t a);
        return a[ADDR_BITS-1 -: BANK_BITS];
    endfunction

    function automatic ofs_t ofs_of(addr_t a);
        return a[OFS_BITS-1:0];
    endfunction

    function automatic word_t preload_word(int unsigned idx);
        return word_t'(idx * PAT_MUL + PAT_ADD);
    endfunction
endpackage

// File: rtl/bdpram_wr_capture.sv
`timescale 1ns/1ps
module bdpram_wr_capture
    import bdpram_pkg::*;
#(
    parameter bit ROM_MODE = 1'b0
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    wr_en,
    input  addr_t   wr_addr,
    input  word_t   wr_data,
    output wr_cmd_t cmd
);
    wr_cmd_t nxt;

    always_comb begin
        nxt.en   = wr_en && !ROM_MODE;
        nxt.addr = wr_addr;
        nxt.data = wr_data;
    end

    always_ff @(posedge clk) begin
        if (rst) cmd <= '0;
        else     cmd <= nxt;
    end

    // R2: a request seen at a rising edge is held for the commit
    p_capture_r2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !ROM_MODE) |=> (cmd.en && cmd.addr == $past(wr_addr) && cmd.data == $past(wr_data)));

    // R9: ROM mode never forwards a write request
    p_rom_block_r9: assert property (@(posedge clk) disable iff (rst)
        (ROM_MODE && wr_en) |=> !cmd.en);
endmodule

// File: rtl/bdpram_tile.sv
`timescale 1ns/1ps
module bdpram_tile
    import bdpram_pkg::*;
#(
    parameter int BANK = 0,
    parameter int LANE = 0
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 we,
    input  ofs_t                 waddr,
    input  logic [TILE_BITS-1:0] wdata,
    input  ofs_t                 raddr,
    output logic [TILE_BITS-1:0] rdata
);
    logic [TILE_BITS-1:0] mem [TILE_WORDS];

    initial begin
        word_t w;
        for (int i = 0; i < TILE_WORDS; i++) begin
            w = preload_word(BANK * TILE_WORDS + i);
            mem[i] = w[LANE*TILE_BITS +: TILE_BITS];
        end
    end

    // commit half a cycle after capture
    always_ff @(negedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];

    // R2: by the next rising edge the committed word equals the request
    p_commit_r2: assert property (@(posedge clk) disable iff (rst)
        we |-> (mem[waddr] == wdata));
endmodule

// File: rtl/bdpram_bank_decode.sv
`timescale 1ns/1ps
module bdpram_bank_decode
    import bdpram_pkg::*;
(
    input  wr_cmd_t              cmd,
    output logic [NUM_BANKS-1:0] bank_we
);
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_dec
        assign bank_we[b] = cmd.en && (bank_of(cmd.addr) == bank_t'(b));
    end
endmodule

// File: rtl/bdpram_read_mux.sv
`timescale 1ns/1ps
module bdpram_read_mux
    import bdpram_pkg::*;
(
    input  logic                                clk,
    input  logic                                rst,
    input  logic                                rd_en,
    input  addr_t                               rd_addr,
    input  logic [NUM_BANKS-1:0][WORD_BITS-1:0] bank_rd,
    output word_t                               rd_data,
    output logic                                rd_oe
);
    word_t sel;

    always_comb begin
        sel = bank_rd[bank_of(rd_addr)];
        rd_oe = rd_en;
        rd_data = rd_en ? sel : '0;
    end

    // R7: released bus carries no data
    p_release_r7: assert property (@(posedge clk) disable iff (rst)
        !rd_en |-> (!rd_oe && rd_data == '0));
endmodule

// File: rtl/banked_dpram.sv
`timescale 1ns/1ps
module banked_dpram
    import bdpram_pkg::*;
#(
    parameter bit ROM_MODE = 1'b0
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic [6:0] wr_addr,
    input  logic [7:0] wr_data,
    input  logic       rd_en,
    input  logic [6:0] rd_addr,
    output logic [7:0] rd_data,
    output logic       rd_oe
);
    wr_cmd_t                             cmd;
    logic [NUM_BANKS-1:0]                bank_we;
    logic [NUM_BANKS-1:0][WORD_BITS-1:0] bank_rd;

    bdpram_wr_capture #(.ROM_MODE(ROM_MODE)) u_cap (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .cmd     (cmd)
    );

    bdpram_bank_decode u_dec (
        .cmd     (cmd),
        .bank_we (bank_we)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        for (genvar l = 0; l < LANES; l++) begin : g_lane
            bdpram_tile #(.BANK(b), .LANE(l)) u_tile (
                .clk   (clk),
                .rst   (rst),
                .we    (bank_we[b]),
                .waddr (ofs_of(cmd.addr)),
                .wdata (cmd.data[l*TILE_BITS +: TILE_BITS]),
                .raddr (ofs_of(rd_addr)),
                .rdata (bank_rd[b][l*TILE_BITS +: TILE_BITS])
            );
        end
    end

    bdpram_read_mux u_rmux (
        .clk     (clk),
        .rst     (rst),
        .rd_en   (rd_en),
        .rd_addr (rd_addr),
        .bank_rd (bank_rd),
        .rd_data (rd_data),
        .rd_oe   (rd_oe)
    );

    // R4: a live request enables exactly one bank, otherwise none
    p_one_bank_r4: assert property (@(posedge clk) disable iff (rst)
        cmd.en ? ($countones(bank_we) == 1) : (bank_we == '0));
endmodule

// File: tb/banked_dpram_test.sv
`timescale 1ns/100ps
module banked_dpram_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [6:0] wr_addr = '0;
    logic [6:0] rd_addr = '0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data, rom_data;
    logic       rd_oe, rom_oe;

    int errors = 0;
    int checks = 0;
    logic [7:0] model [128];

    // 250 MHz
    always #2 clk = ~clk;

    banked_dpram uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .rd_oe(rd_oe)
    );

    banked_dpram #(.ROM_MODE(1'b1)) uut_rom (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rom_data), .rd_oe(rom_oe)
    );

    // {address, data}
    localparam logic [14:0] VEC [8] = '{
        {7'd0,   8'hA5}, {7'd31,  8'h3C}, {7'd32,  8'hC3}, {7'd63,  8'h0F},
        {7'd64,  8'hF0}, {7'd95,  8'h81}, {7'd96,  8'h7E}, {7'd127, 8'h5A}
    };

    function automatic logic [7:0] start_val(int i);
        return 8'((i * 29 + 90) % 256);
    endfunction

    task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic rd_chk(string tag, logic [6:0] a);
        @(posedge clk);
        #1 rd_addr = a;
        #0.5 chk(tag, rd_data, model[a]);
    endtask

    // write with read address tied to write address
    task automatic do_write(logic [6:0] a, logic [7:0] d);
        @(posedge clk);
        #1 wr_en = 1'b1; wr_addr = a; wr_data = d; rd_addr = a; rd_en = 1'b1;
        #0.5 chk("R2 before capture", rd_data, model[a]);
        @(posedge clk);
        #1 chk("R3 captured not committed", rd_data, model[a]);
        wr_en = 1'b0;
        @(negedge clk);
        #1 model[a] = d;
        chk("R3 after commit", rd_data, d);
        chk("R9 rom unchanged", rom_data, start_val(a));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < 128; i++) model[i] = start_val(i);

        // reset state and R7 release
        @(posedge clk);
        #1 chk("R7 oe low in reset", {7'd0, rd_oe}, 8'd0);
        chk("R7 data zero when released", rd_data, 8'h00);
        rd_en = 1'b1;
        rd_addr = 7'd10;
        #0.5 chk("R1 preload word 10", rd_data, start_val(10));
        chk("R7 oe high when enabled", {7'd0, rd_oe}, 8'd1);
        repeat (2) @(posedge clk);
        #1 rst = 1'b0;

        // R5: two addresses inside one clock phase
        @(posedge clk);
        #0.5 rd_addr = 7'd3;
        #0.5 chk("R5 async read 3", rd_data, start_val(3));
        rd_addr = 7'd100;
        #0.5 chk("R5 async read 100", rd_data, start_val(100));

        // table walk: bank edges, distinct nibbles (R4, R6)
        for (int k = 0; k < 8; k++) begin
            do_write(VEC[k][14:8], VEC[k][7:0]);
            rd_chk("R6 R8 readback next cycle", VEC[k][14:8]);
        end

        // R4: nothing else moved
        for (int a = 0; a < 128; a++) rd_chk("R4 full scan", 7'(a));

        // R8 back-to-back writes to one address
        do_write(7'd20, 8'h11);
        do_write(7'd20, 8'h22);
        rd_chk("R8 last write wins", 7'd20);

        // R10: write held during reset is dropped
        @(posedge clk);
        #1 rst = 1'b1; wr_en = 1'b1; wr_addr = 7'd5; wr_data = 8'hEE;
        @(posedge clk);
        #1 wr_en = 1'b0;
        @(posedge clk);
        #1 rst = 1'b0;
        rd_chk("R10 write in reset ignored", 7'd5);
        rd_chk("R1 reset keeps written word", 7'd0);
        rd_chk("R1 reset keeps word 127", 7'd127);

        // R7 release after traffic
        @(posedge clk);
        #1 rd_en = 1'b0; rd_addr = 7'd0;
        #0.5 chk("R7 data zero when released", rd_data, 8'h00);
        chk("R7 oe low", {7'd0, rd_oe}, 8'd0);
        rd_en = 1'b1;
        #0.5 chk("R7 data back when enabled", rd_data, 8'hA5);

        // R9 ROM instance across written addresses
        for (int k = 0; k < 8; k++) begin
            @(posedge clk);
            #1 rd_addr = VEC[k][14:8];
            #0.5 chk("R9 rom keeps start value", rom_data, start_val(VEC[k][14:8]));
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule